// File: doc/BRIEF.md
# I2C Register Target with Bus Watchdog

This block is an I2C target that lets an external host reach a 64-entry byte register file inside the chip. It watches SCL and SDA on the fast system clock. Both lines pass through two-flop synchronisers. The block detects START, repeated START and STOP, and answers only to its own 7-bit device address. That address is taken from a strap input at reset. The block drives SDA only by pulling it low, so its SDA output is an open-drain enable.

A host writes registers by sending the device address with the write bit, then a register index, then one or more data bytes. To read, it sets the index the same way, issues a repeated START, and sends the address again with the read bit. The register pointer steps after every data byte in both directions. On reads, the step from index 0x12 goes back to 0x03, so a host can loop over a block of sample and status registers in a single burst.

A busy output is high from START to STOP, so that neighbouring logic can hold sample and event registers still while a transfer runs. If a master stops clocking in the middle of a read, an optional bus watchdog returns the target to idle, releases SDA and sets a sticky status flag.

Top module: `i2c_regslave`

## Requirements
- R1: After reset, SDA is released, busy is low, and every register reads 0x00.
- R2: The device address is latched at reset: 0x4C when the strap is low, 0x6C when it is high. A later change of the strap has no effect. Any other address gets a NAK and changes nothing.
- R3: A write transfer is the device byte (bit 0 = 0), a register index, then data. A read transfer sets the index, issues a repeated START, then sends the device byte with bit 0 = 1. The target pulls SDA low on the 9th clock of every byte it receives.
- R4: The pointer steps by one after each data byte in a burst, for writes and for reads, modulo 64 outside the read wrap.
- R5: In a burst read, the byte after index 0x12 comes from index 0x03.
- R6: Busy rises on START, stays high across a repeated START, and falls on STOP.
- R7: With bit 0 of the mode register (index 0x07) set, SCL held still for more than WD_TICKS system clocks during a read releases SDA, lowers busy and sets bit 4 of the status register (index 0x04).
- R8: A read of index 0x04 returns the watchdog flag in bit 4 and clears it, so the next read returns 0x00.
- R9: With mode bit 0 clear, a stalled read keeps SDA held, and the byte finishes normally when clocking resumes.
- R10: A NAK from the master ends the read burst. The target drives nothing until the next START.
- R11: Writes to index 0x04 and to indices 0x3C to 0x3F are ACKed and have no effect. Indices 0x3C to 0x3F read as 0x00, and index 0x04 holds only the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; strap is sampled while it is high |
| strap_hi | input | 1 | Address strap: 0 selects 0x4C, 1 selects 0x6C |
| scl_in | input | 1 | SCL line level (asynchronous) |
| sda_in | input | 1 | SDA line level (asynchronous) |
| sda_pull | output | 1 | When high, the pad pulls SDA low |
| xfer_busy | output | 1 | High between a recognised START and the following STOP |

## Verification
The main function is tried with a 64-byte burst write of an arithmetic pattern, which sweeps every index. Two burst reads then cover the whole file: one on each side of the wrap. Together they show that the pointer steps correctly, that writable and protected indices differ, and that the wrap fires only on reads. A short burst that crosses 0x12, and single writes and reads, separate wrap errors from plain increment errors. Stalled reads with the watchdog on and off separate a real timeout from a premature release. A reset with the strap high, followed by traffic to both addresses, tells address latching apart from live strap decoding.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } bus_st_e;

    typedef enum logic [1:0] {
        RX_DEV,
        RX_REG,
        RX_DATA
    } rx_kind_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_ev_t;

    localparam logic [6:0] DEV_ADDR_LO = 7'h4C;
    localparam logic [6:0] DEV_ADDR_HI = 7'h6C;
    localparam logic [7:0] WRAP_LAST   = 8'h12;
    localparam logic [7:0] WRAP_FIRST  = 8'h03;

    // Pointer step used on reads: loops the sample window.
    function automatic logic [7:0] rd_next(input logic [7:0] p);
        return (p == WRAP_LAST) ? WRAP_FIRST : p + 8'd1;
    endfunction

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/i2cs_wdog.sv
module i2cs_wdog #(
    parameter int TICKS = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic armed,
    input  logic kick,
    output logic fire
);
    localparam int CW = $clog2(TICKS + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en || !armed || kick) cnt <= '0;
        else if (cnt == CW'(TICKS - 1))   cnt <= '0;
        else                              cnt <= cnt + 1'b1;
    end

    assign fire = en && armed && !kick && (cnt == CW'(TICKS - 1));
endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs #(
    parameter int NREG      = 64,
    parameter int STAT_ADDR = 4,
    parameter int MODE_ADDR = 7,
    parameter int RSV_BASE  = 60,
    parameter int FLAG_BIT  = 4,
    localparam int AW       = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    input  logic          rd_take,
    input  logic          wd_fire,
    output logic [7:0]    rd_data,
    output logic          wd_en
);
    localparam logic [AW-1:0] STAT_A = AW'(STAT_ADDR);

    logic [7:0] mem [NREG];
    logic       wd_flag;

    for (genvar i = 0; i < NREG; i++) begin : g_ent
        if (i == STAT_ADDR || i >= RSV_BASE) begin : g_ro
            always_ff @(posedge clk) mem[i] <= 8'h00;
        end else begin : g_rw
            always_ff @(posedge clk) begin
                if (rst)                                 mem[i] <= 8'h00;
                else if (wr_en && wr_addr == AW'(i))     mem[i] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                               wd_flag <= 1'b0;
        else if (wd_fire)                      wd_flag <= 1'b1;
        else if (rd_take && rd_addr == STAT_A) wd_flag <= 1'b0;
    end

    always_comb begin
        if (rd_addr == STAT_A) rd_data = 8'(wd_flag) << FLAG_BIT;
        else                   rd_data = mem[rd_addr];
    end

    assign wd_en = mem[MODE_ADDR][0];

    // R7
    wd_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        wd_fire |=> wd_flag);
    // R8
    wd_flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_take && rd_addr == STAT_A && !wd_fire) |=> !wd_flag);
endmodule

// File: rtl/i2cs_bus.sv
module i2cs_bus
    import i2cs_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_s,
    input  logic          sda_s,
    input  logic [6:0]    dev_addr,
    input  logic          wd_fire,
    input  logic [7:0]    rd_data,
    output logic          sda_oe,
    output logic          busy,
    output logic          in_read,
    output logic          scl_edge,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic [AW-1:0] ptr,
    output logic          rd_take
);
    logic     scl_q, sda_q;
    bus_ev_t  ev;
    bus_st_e  state;
    rx_kind_e kind;
    logic [3:0] cnt;
    logic [7:0] shreg;
    logic       is_rd, mack_ok, load_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        ev.rise  = scl_s && !scl_q;
        ev.fall  = !scl_s && scl_q;
        ev.start = scl_s && scl_q && sda_q && !sda_s;
        ev.stop  = scl_s && scl_q && !sda_q && sda_s;
    end

    assign load_rd  = ev.fall && ((state == ST_ACK && is_rd) ||
                                  (state == ST_MACK && cnt == 4'd1 && mack_ok));
    assign rd_take  = load_rd;
    assign scl_edge = ev.rise || ev.fall;
    assign in_read  = (state == ST_TX) || (state == ST_MACK) ||
                      (state == ST_ACK && is_rd);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            kind    <= RX_DEV;
            cnt     <= '0;
            shreg   <= '0;
            is_rd   <= 1'b0;
            mack_ok <= 1'b0;
            sda_oe  <= 1'b0;
            busy    <= 1'b0;
            ptr     <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (wd_fire) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
                busy   <= 1'b0;
            end else if (ev.start) begin
                state  <= ST_RX;
                kind   <= RX_DEV;
                cnt    <= '0;
                sda_oe <= 1'b0;
                busy   <= 1'b1;
            end else if (ev.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
                busy   <= 1'b0;
            end else if (load_rd) begin
                shreg  <= rd_data;
                sda_oe <= !rd_data[7];
                ptr    <= AW'(rd_next(8'(ptr)));
                cnt    <= '0;
                state  <= ST_TX;
            end else begin
                case (state)
                    ST_RX: begin
                        if (ev.rise && cnt != 4'd8) begin
                            shreg <= {shreg[6:0], sda_s};
                            cnt   <= cnt + 4'd1;
                        end else if (ev.fall && cnt == 4'd8) begin
                            case (kind)
                                RX_DEV: begin
                                    if (shreg[7:1] == dev_addr) begin
                                        is_rd  <= shreg[0];
                                        sda_oe <= 1'b1;
                                        state  <= ST_ACK;
                                    end else begin
                                        state  <= ST_IDLE;
                                    end
                                end
                                RX_REG: begin
                                    ptr    <= shreg[AW-1:0];
                                    sda_oe <= 1'b1;
                                    state  <= ST_ACK;
                                end
                                default: begin
                                    wr_en   <= 1'b1;
                                    wr_addr <= ptr;
                                    wr_data <= shreg;
                                    ptr     <= ptr + 1'b1;
                                    sda_oe  <= 1'b1;
                                    state   <= ST_ACK;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (ev.fall) begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            state  <= ST_RX;
                            kind   <= (kind == RX_DEV) ? RX_REG : RX_DATA;
                        end
                    end
                    ST_TX: begin
                        if (ev.fall) begin
                            if (cnt == 4'd7) begin
                                sda_oe <= 1'b0;
                                cnt    <= '0;
                                state  <= ST_MACK;
                            end else begin
                                shreg  <= {shreg[6:0], 1'b0};
                                sda_oe <= !shreg[6];
                                cnt    <= cnt + 4'd1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (ev.rise) begin
                            mack_ok <= !sda_s;
                            cnt     <= 4'd1;
                        end else if (ev.fall && cnt == 4'd1) begin
                            state <= ST_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R6
    busy_on_start_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.start && !wd_fire) |=> busy);
    // R6
    idle_on_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.stop && !wd_fire) |=> !busy);
    // R7
    wd_release_chk: assert property (@(posedge clk) disable iff (rst)
        wd_fire |=> (!sda_oe && state == ST_IDLE));
    // R5
    rd_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (load_rd && !wd_fire && ptr == AW'(WRAP_LAST)) |=> ptr == AW'(WRAP_FIRST));
endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave
    import i2cs_pkg::*;
#(
    parameter int NREG        = 64,
    parameter int WD_TICKS    = 50000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strap_hi,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_pull,
    output logic xfer_busy
);
    localparam int AW = $clog2(NREG);

    logic [1:0]    raw, syncd;
    logic [6:0]    dev_addr;
    logic          wd_fire, wd_en, in_read, scl_edge;
    logic          wr_en, rd_take;
    logic [AW-1:0] wr_addr, ptr;
    logic [7:0]    wr_data, rd_data;

    assign raw = {sda_in, scl_in};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst(rst), .d(raw[g]), .q(syncd[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) dev_addr <= strap_hi ? DEV_ADDR_HI : DEV_ADDR_LO;
    end

    i2cs_bus #(.AW(AW)) u_bus (
        .clk(clk), .rst(rst), .scl_s(syncd[0]), .sda_s(syncd[1]),
        .dev_addr(dev_addr), .wd_fire(wd_fire), .rd_data(rd_data),
        .sda_oe(sda_pull), .busy(xfer_busy), .in_read(in_read),
        .scl_edge(scl_edge), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ptr(ptr), .rd_take(rd_take)
    );

    i2cs_regs #(.NREG(NREG)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(ptr), .rd_take(rd_take),
        .wd_fire(wd_fire), .rd_data(rd_data), .wd_en(wd_en)
    );

    i2cs_wdog #(.TICKS(WD_TICKS)) u_wdog (
        .clk(clk), .rst(rst), .en(wd_en), .armed(in_read),
        .kick(scl_edge), .fire(wd_fire)
    );

    // R7
    idle_bus_released_chk: assert property (@(posedge clk) disable iff (rst)
        !xfer_busy |-> !sda_pull);
endmodule

// File: tb/tb_i2c_regslave.sv
module tb_i2c_regslave;
    localparam int H = 12;
    localparam logic [6:0] A_LO = 7'h4C;
    localparam logic [6:0] A_HI = 7'h6C;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic strap_hi = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull, xfer_busy;
    wire  sda_line = sda_m & ~sda_pull;

    int errors = 0;
    int checks = 0;
    logic [7:0] wbuf [64];
    logic [7:0] rbuf [64];

    always #2 clk = ~clk;

    i2c_regslave #(.WD_TICKS(200)) dut (
        .clk(clk), .rst(rst), .strap_hi(strap_hi), .scl_in(scl_m),
        .sda_in(sda_line), .sda_pull(sda_pull), .xfer_busy(xfer_busy)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 5) & 255);
    endfunction

    function automatic logic [7:0] expv(input int a);
        if (a == 4 || a >= 8'h3C) return 8'h00;
        return pat(a);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hb();
        repeat (H) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; hb(); scl_m = 1'b1; hb(); sda_m = 1'b0; hb(); scl_m = 1'b0; hb();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; hb(); scl_m = 1'b1; hb(); sda_m = 1'b1; hb();
    endtask

    task automatic wbyte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hb(); scl_m = 1'b1; hb(); scl_m = 1'b0; hb();
        end
        sda_m = 1'b1; hb(); scl_m = 1'b1; hb();
        ack = !sda_line;
        scl_m = 1'b0; hb();
    endtask

    task automatic rbyte(output logic [7:0] b, input bit nak);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hb(); scl_m = 1'b1; hb(); b[i] = sda_line; scl_m = 1'b0;
        end
        hb(); sda_m = nak; hb(); scl_m = 1'b1; hb(); scl_m = 1'b0; hb(); sda_m = 1'b1;
    endtask

    task automatic wr_regs(input logic [6:0] dev, input logic [7:0] a, input int n, output bit ok);
        bit ack;
        i2c_start();
        wbyte({dev, 1'b0}, ack); ok = ack;
        if (ack) begin
            wbyte(a, ack); ok &= ack;
            for (int k = 0; k < n; k++) begin
                wbyte(wbuf[k], ack); ok &= ack;
            end
        end
        i2c_stop();
    endtask

    task automatic rd_regs(input logic [6:0] dev, input logic [7:0] a, input int n, output bit ok);
        bit ack;
        i2c_start();
        wbyte({dev, 1'b0}, ack); ok = ack;
        wbyte(a, ack); ok &= ack;
        i2c_start();
        wbyte({dev, 1'b1}, ack); ok &= ack;
        for (int k = 0; k < n; k++) rbyte(rbuf[k], k == n - 1);
        i2c_stop();
    endtask

    task automatic wr1(input logic [7:0] a, input logic [7:0] d);
        bit ok;
        wbuf[0] = d;
        wr_regs(A_LO, a, 1, ok);
        chk("R3 write ack", 32'(ok), 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit ok, ack, seen;
        logic [7:0] b;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        // R1
        chk("R1 sda released", 32'(sda_pull), 0);
        chk("R1 busy low", 32'(xfer_busy), 0);
        rd_regs(A_LO, 8'h2A, 1, ok);
        chk("R1 reg reset", 32'(rbuf[0]), 0);

        // R2: wrong address is refused and changes nothing
        wbuf[0] = 8'h77;
        wr_regs(A_HI, 8'h2A, 1, ok);
        chk("R2 foreign addr nak", 32'(ok), 0);
        rd_regs(A_LO, 8'h2A, 1, ok);
        chk("R2 own addr ack", 32'(ok), 1);
        chk("R2 foreign write ignored", 32'(rbuf[0]), 0);

        // R3: single write and read back
        wr1(8'h2A, 8'hC3);
        rd_regs(A_LO, 8'h2A, 1, ok);
        chk("R3 read ack", 32'(ok), 1);
        chk("R3 read back", 32'(rbuf[0]), 32'hC3);

        // R4 / R11: full burst write, then reads on both sides of the wrap
        for (int k = 0; k < 64; k++) wbuf[k] = pat(k);
        wr_regs(A_LO, 8'h00, 64, ok);
        chk("R11 burst write acked incl protected", 32'(ok), 1);
        rd_regs(A_LO, 8'h13, 45, ok);
        for (int k = 0; k < 45; k++) chk("R4 burst read upper", 32'(rbuf[k]), 32'(expv(8'h13 + k)));
        rd_regs(A_LO, 8'h00, 19, ok);
        for (int k = 0; k < 19; k++) chk("R4 burst read lower", 32'(rbuf[k]), 32'(expv(k)));
        chk("R11 reserved reads zero", 32'(rbuf[4]), 0);

        // R5: wrap from 0x12 to 0x03
        rd_regs(A_LO, 8'h10, 8, ok);
        chk("R5 0x10", 32'(rbuf[0]), 32'(expv(8'h10)));
        chk("R5 0x12", 32'(rbuf[2]), 32'(expv(8'h12)));
        chk("R5 wrap to 0x03", 32'(rbuf[3]), 32'(expv(3)));
        chk("R5 then 0x04", 32'(rbuf[4]), 0);
        chk("R5 then 0x07", 32'(rbuf[7]), 32'(expv(7)));

        // R11: status and reserved writes ignored
        wr1(8'h04, 8'hFF);
        wr1(8'h3D, 8'hAA);
        rd_regs(A_LO, 8'h04, 1, ok);
        chk("R11 status write ignored", 32'(rbuf[0]), 0);
        rd_regs(A_LO, 8'h3D, 1, ok);
        chk("R11 reserved write ignored", 32'(rbuf[0]), 0);

        // R6: busy through repeated START
        i2c_start();
        chk("R6 busy after start", 32'(xfer_busy), 1);
        wbyte({A_LO, 1'b0}, ack);
        wbyte(8'h2A, ack);
        i2c_start();
        chk("R6 busy across restart", 32'(xfer_busy), 1);
        wbyte({A_LO, 1'b1}, ack);
        rbyte(b, 1'b0);
        chk("R4 read ack burst first", 32'(b), 32'(pat(8'h2A)));
        rbyte(b, 1'b1);
        chk("R4 read ack burst second", 32'(b), 32'(pat(8'h2B)));
        // R10: after NAK the target drives nothing
        seen = 1'b0;
        for (int i = 0; i < 9; i++) begin
            hb(); scl_m = 1'b1; hb(); if (sda_pull) seen = 1'b1; scl_m = 1'b0;
        end
        hb();
        chk("R10 silent after nak", 32'(seen), 0);
        i2c_stop();
        chk("R6 busy low after stop", 32'(xfer_busy), 0);

        // R7: watchdog on, stall inside a read
        wr1(8'h05, 8'h00);
        wr1(8'h07, 8'h01);
        i2c_start();
        wbyte({A_LO, 1'b0}, ack);
        wbyte(8'h05, ack);
        i2c_start();
        wbyte({A_LO, 1'b1}, ack);
        chk("R7 target holding sda", 32'(sda_pull), 1);
        repeat (400) @(negedge clk);
        chk("R7 sda released", 32'(sda_pull), 0);
        chk("R7 busy dropped", 32'(xfer_busy), 0);
        i2c_stop();
        // R8
        rd_regs(A_LO, 8'h04, 1, ok);
        chk("R8 flag bit4", 32'(rbuf[0]), 32'h10);
        rd_regs(A_LO, 8'h04, 1, ok);
        chk("R8 flag cleared", 32'(rbuf[0]), 0);

        // R9: watchdog off keeps SDA held
        wr1(8'h07, 8'h00);
        i2c_start();
        wbyte({A_LO, 1'b0}, ack);
        wbyte(8'h05, ack);
        i2c_start();
        wbyte({A_LO, 1'b1}, ack);
        repeat (400) @(negedge clk);
        chk("R9 sda still held", 32'(sda_pull), 1);
        rbyte(b, 1'b1);
        chk("R9 byte completes", 32'(b), 0);
        i2c_stop();
        rd_regs(A_LO, 8'h04, 1, ok);
        chk("R9 no flag", 32'(rbuf[0]), 0);

        // R2 / R1: reset with strap high
        strap_hi = 1'b1;
        rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        strap_hi = 1'b0;
        repeat (5) @(negedge clk);
        rd_regs(A_HI, 8'h2A, 1, ok);
        chk("R2 strap high addr ack", 32'(ok), 1);
        chk("R1 regs cleared by reset", 32'(rbuf[0]), 0);
        wbuf[0] = 8'h5A;
        wr_regs(A_LO, 8'h08, 1, ok);
        chk("R2 low addr refused", 32'(ok), 0);
        wr_regs(A_HI, 8'h08, 1, ok);
        rd_regs(A_HI, 8'h08, 1, ok);
        chk("R2 latched strap", 32'(rbuf[0]), 32'h5A);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule